// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical page by reading a radix tree of 64-bit translation entries, four levels deep, beginning at the table whose frame number is held in a root input. It works one translation at a time. It uses a memory port that allows a single outstanding request, and that port carries both the entry reads and the write-backs of the accessed and dirty flags. The walk ends at level 1 with a 4 KB page. It can also end earlier, at level 2 with a 2 MB page or at level 3 with a 1 GB page, when the page-size flag (bit 7) of the entry is set.

Every entry read is checked for presence and for reserved bits. The reserved-bit mask grows during the walk: it always covers the address bits above the supported physical width, and it covers bit 63 when no-execute is turned off. At the top level it also covers bit 7. At a large-page leaf it covers the address bits below the page size, except bit 12. When a leaf passes these checks, its combined attributes go to an external permission checker. The leaf flags are written back only if that checker allows the access. The walk then reports the page base, the page size, the combined attributes and a fault cause with a one-cycle completion pulse.

States: IDLE (waits for a request; a non-canonical address goes straight to FINISH, any other address goes to FETCH), FETCH (reads the current entry; goes to CHECK on handshake), CHECK (judges the entry; goes to FINISH on a fault, PERM at a leaf, MARK for a non-leaf whose accessed flag is clear, otherwise FETCH for the next level), MARK (writes the accessed flag into the non-leaf entry, then goes to FETCH), PERM (waits for the checker; goes to FINISH on denial or when nothing needs updating, otherwise UPDATE), UPDATE (writes the leaf flags back, then goes to FINISH), FINISH (raises `done` for one cycle, then returns to IDLE).

Top module: `pt_walker`

## Requirements
- R1: If bits 63:47 of the request address are not all equal, the walk ends with fault cause 4 and makes no memory access.
- R2: The first read goes to `{root_frame, va[47:39], 3'b000}`. Each later read goes to `{entry[39:12], idx, 3'b000}`, where idx is va[38:30], va[29:21] and va[20:12] for levels 3, 2 and 1, and entry is the entry read at the level above.
- R3: An entry with bit 0 clear ends the walk with fault cause 1. No later read is made.
- R4: An entry with any bit set in 51:40, or with bit 63 set while `nx_enable` is low, ends the walk with fault cause 2.
- R5: A level-4 entry with bit 7 set ends the walk with fault cause 2.
- R6: A successful walk reports `page_size` as 0, 1 or 2 for a leaf at level 1, 2 or 3, where a level-3 or level-2 entry with bit 7 set is a leaf. It reports `page_pa` as entry bits 39:12 with the bits below the page size cleared, and fault cause 0.
- R7: At a level-2 or level-3 leaf, any set bit from bit 13 up to the bit below the page size gives fault cause 2. Bit 12 never does.
- R8: A non-leaf entry whose bit 5 is clear is written back to the same address with bit 5 set, before the next level is read. A non-leaf entry whose bit 5 is already set is not written.
- R9: A leaf is written back only after the checker allows the access, and only if bit 5 is clear, or if the access is a write and bit 6 is clear. The written value sets bit 5, and also bit 6 on a write. A denial gives fault cause 3 and no leaf write.
- R10: `attr_rw` is the AND of bit 1 over the walked entries, `attr_user` is the AND of bit 2, and `attr_nx` is the OR of bit 63.
- R11: `req_ready` is high only when no walk is in progress. A memory request keeps its address and direction until `mem_ready` is seen.
- R12: `done` lasts one cycle, follows every write-back, and comes with no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vpn | input | 52 | Virtual address bits 63:12 |
| req_write | input | 1 | Access is a write |
| nx_enable | input | 1 | No-execute bit in use |
| root_frame | input | 28 | Frame number of the top table |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts; read data valid this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 40 | Entry byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data |
| chk_req | output | 1 | Leaf attributes ready for permission check |
| chk_write | output | 1 | Access direction for the checker |
| chk_done | input | 1 | Checker answer valid |
| chk_allow | input | 1 | Checker permits access |
| done | output | 1 | Walk complete pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_cause | output | 3 | 0 none, 1 absent, 2 reserved, 3 denied, 4 non-canonical |
| page_pa | output | 40 | Physical page base |
| page_size | output | 2 | 0 4 KB, 1 2 MB, 2 1 GB |
| attr_rw | output | 1 | Combined writable |
| attr_user | output | 1 | Combined user access |
| attr_nx | output | 1 | Combined no-execute |

## Verification
The leaf decision and the reserved-bit check are made on the same entry in the same CHECK cycle. A level-2 or level-3 entry with bit 7 set is therefore both a candidate leaf and a subject of the low-bit reserved mask, and the fault has to win. The stimulus provokes this by placing junk in the bits under the page size of large entries while bit 12 is left random. It judges the outcome by the reported cause and by whether a leaf write-back appears on the memory port. Random memory stalls also land write-backs and reads on both sides of the permission answer.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned ENT_W      = 64;

    localparam int unsigned B_PRESENT  = 0;
    localparam int unsigned B_WRITE    = 1;
    localparam int unsigned B_USER     = 2;
    localparam int unsigned B_ACCESSED = 5;
    localparam int unsigned B_DIRTY    = 6;
    localparam int unsigned B_LARGE    = 7;
    localparam int unsigned B_NOEXEC   = 63;
    localparam int unsigned ADDR_TOP   = 51;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ABSENT   = 3'd1,
        FLT_RSVD     = 3'd2,
        FLT_DENY     = 3'd3,
        FLT_NONCANON = 3'd4
    } walk_fault_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_MARK,
        S_PERM,
        S_UPDATE,
        S_FINISH
    } walk_state_e;

endpackage

// File: rtl/pgw_addr_calc.sv
module pgw_addr_calc
    import pgw_pkg::*;
#(
    parameter int unsigned VA_BITS  = 48,
    parameter int unsigned PA_BITS  = 40,
    parameter int unsigned LEVELS   = 4,
    parameter int unsigned IDX_BITS = 9,
    localparam int unsigned LVL_W   = $clog2(LEVELS + 1),
    localparam int unsigned FRAME_W = PA_BITS - PAGE_SHIFT
)(
    input  logic [FRAME_W-1:0]          base_frame,
    input  logic [VA_BITS-1:PAGE_SHIFT] vpn,
    input  logic [LVL_W-1:0]            level,
    output logic [PA_BITS-1:0]          entry_addr
);

    localparam int unsigned SLOT_SHIFT = PAGE_SHIFT - IDX_BITS;

    logic [IDX_BITS-1:0] idx_tab [LEVELS];
    logic [IDX_BITS-1:0] idx_sel;

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_tab[g] = vpn[PAGE_SHIFT + IDX_BITS*g +: IDX_BITS];
    end

    always_comb begin
        idx_sel = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i + 1)) begin
                idx_sel = idx_tab[i];
            end
        end
    end

    assign entry_addr = {base_frame, idx_sel, {SLOT_SHIFT{1'b0}}};

endmodule

// File: rtl/pgw_entry_eval.sv
module pgw_entry_eval
    import pgw_pkg::*;
#(
    parameter int unsigned PA_BITS   = 40,
    parameter int unsigned LEVELS    = 4,
    parameter int unsigned IDX_BITS  = 9,
    parameter int unsigned LARGE_TOP = 3,
    localparam int unsigned LVL_W    = $clog2(LEVELS + 1)
)(
    input  logic [ENT_W-1:0] entry,
    input  logic [LVL_W-1:0] level,
    input  logic             nx_on,
    output logic             present,
    output logic             reserved,
    output logic             is_leaf,
    output logic [1:0]       size_code
);

    function automatic logic [ENT_W-1:0] span(input int hi, input int lo);
        logic [ENT_W-1:0] m;
        m = '0;
        for (int b = 0; b < ENT_W; b++) begin
            if (b <= hi && b >= lo) m[b] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [ENT_W-1:0] HI_RSVD = span(ADDR_TOP, PA_BITS);

    logic [ENT_W-1:0] low_tab [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_low
        if (g > 0 && g < LARGE_TOP) begin : g_big
            assign low_tab[g] = span(PAGE_SHIFT + IDX_BITS*g - 1, PAGE_SHIFT + 1);
        end else begin : g_none
            assign low_tab[g] = '0;
        end
    end

    logic             large_ok;
    logic [ENT_W-1:0] low_sel;

    always_comb begin
        low_sel = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i + 1)) low_sel = low_tab[i];
        end
    end

    assign large_ok  = (level >= LVL_W'(2)) && (level <= LVL_W'(LARGE_TOP));
    assign present   = entry[B_PRESENT];
    assign is_leaf   = (level == LVL_W'(1)) || (large_ok && entry[B_LARGE]);
    assign size_code = 2'(level - LVL_W'(1));

    assign reserved = (|(entry & HI_RSVD))
                    | (!nx_on && entry[B_NOEXEC])
                    | ((level == LVL_W'(LEVELS)) && entry[B_LARGE])
                    | (large_ok && entry[B_LARGE] && (|(entry & low_sel)));

endmodule

// File: rtl/pgw_leaf_fmt.sv
module pgw_leaf_fmt
    import pgw_pkg::*;
#(
    parameter int unsigned PA_BITS   = 40,
    parameter int unsigned IDX_BITS  = 9,
    parameter int unsigned LARGE_TOP = 3,
    localparam int unsigned FRAME_W  = PA_BITS - PAGE_SHIFT
)(
    input  logic [FRAME_W-1:0] frame,
    input  logic [1:0]         size_code,
    output logic [PA_BITS-1:0] page_base
);

    logic [PA_BITS-1:0] base_tab [LARGE_TOP];
    logic [PA_BITS-1:0] full;

    assign full = {frame, {PAGE_SHIFT{1'b0}}};

    for (genvar s = 0; s < LARGE_TOP; s++) begin : g_size
        localparam int unsigned SH = PAGE_SHIFT + IDX_BITS*s;
        localparam logic [PA_BITS-1:0] KEEP = ~PA_BITS'((64'd1 << SH) - 64'd1);
        assign base_tab[s] = full & KEEP;
    end

    always_comb begin
        page_base = '0;
        for (int i = 0; i < LARGE_TOP; i++) begin
            if (size_code == 2'(i)) page_base = base_tab[i];
        end
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pgw_pkg::*;
#(
    parameter int unsigned VA_BITS   = 48,
    parameter int unsigned PA_BITS   = 40,
    parameter int unsigned LEVELS    = 4,
    parameter int unsigned IDX_BITS  = 9,
    parameter int unsigned LARGE_TOP = 3
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [63:PAGE_SHIFT]     req_vpn,
    input  logic                     req_write,
    input  logic                     nx_enable,
    input  logic [PA_BITS-13:0]      root_frame,
    output logic                     mem_valid,
    input  logic                     mem_ready,
    output logic                     mem_we,
    output logic [PA_BITS-1:0]       mem_addr,
    output logic [63:0]              mem_wdata,
    input  logic [63:0]              mem_rdata,
    output logic                     chk_req,
    output logic                     chk_write,
    input  logic                     chk_done,
    input  logic                     chk_allow,
    output logic                     done,
    output logic                     fault,
    output logic [2:0]               fault_cause,
    output logic [PA_BITS-1:0]       page_pa,
    output logic [1:0]               page_size,
    output logic                     attr_rw,
    output logic                     attr_user,
    output logic                     attr_nx
);

    localparam int unsigned LVL_W   = $clog2(LEVELS + 1);
    localparam int unsigned FRAME_W = PA_BITS - PAGE_SHIFT;

    walk_state_e state_q, state_d;

    logic [VA_BITS-1:PAGE_SHIFT] va_q;
    logic                        wr_q;
    logic                        nx_q;
    logic [LVL_W-1:0]            lvl_q;
    logic [ENT_W-1:0]            ent_q;
    logic [PA_BITS-1:0]          addr_q;
    logic                        rw_acc, us_acc, nx_acc;
    walk_fault_e                 cause_q;
    logic [PA_BITS-1:0]          pa_q;
    logic [1:0]                  size_q;

    logic canonical;
    assign canonical = (&req_vpn[63:VA_BITS-1]) || !(|req_vpn[63:VA_BITS-1]);

    // next entry address: root table on accept, child table otherwise
    logic [FRAME_W-1:0]           calc_base;
    logic [VA_BITS-1:PAGE_SHIFT]  calc_vpn;
    logic [LVL_W-1:0]             calc_lvl;
    logic [PA_BITS-1:0]           next_addr;

    assign calc_base = (state_q == S_IDLE) ? root_frame : ent_q[PA_BITS-1:PAGE_SHIFT];
    assign calc_vpn  = (state_q == S_IDLE) ? req_vpn[VA_BITS-1:PAGE_SHIFT] : va_q;
    assign calc_lvl  = (state_q == S_IDLE) ? LVL_W'(LEVELS) : lvl_q - LVL_W'(1);

    pgw_addr_calc #(
        .VA_BITS(VA_BITS), .PA_BITS(PA_BITS), .LEVELS(LEVELS), .IDX_BITS(IDX_BITS)
    ) u_addr (
        .base_frame(calc_base),
        .vpn       (calc_vpn),
        .level     (calc_lvl),
        .entry_addr(next_addr)
    );

    logic       e_present, e_rsvd, e_leaf;
    logic [1:0] e_size;

    pgw_entry_eval #(
        .PA_BITS(PA_BITS), .LEVELS(LEVELS), .IDX_BITS(IDX_BITS), .LARGE_TOP(LARGE_TOP)
    ) u_eval (
        .entry    (ent_q),
        .level    (lvl_q),
        .nx_on    (nx_q),
        .present  (e_present),
        .reserved (e_rsvd),
        .is_leaf  (e_leaf),
        .size_code(e_size)
    );

    logic [PA_BITS-1:0] leaf_base;

    pgw_leaf_fmt #(
        .PA_BITS(PA_BITS), .IDX_BITS(IDX_BITS), .LARGE_TOP(LARGE_TOP)
    ) u_fmt (
        .frame    (ent_q[PA_BITS-1:PAGE_SHIFT]),
        .size_code(e_size),
        .page_base(leaf_base)
    );

    logic leaf_stale;
    assign leaf_stale = !ent_q[B_ACCESSED] || (wr_q && !ent_q[B_DIRTY]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = canonical ? S_FETCH : S_FINISH;
            S_FETCH:  if (mem_ready) state_d = S_CHECK;
            S_CHECK: begin
                if (!e_present || e_rsvd)      state_d = S_FINISH;
                else if (e_leaf)               state_d = S_PERM;
                else if (!ent_q[B_ACCESSED])   state_d = S_MARK;
                else                           state_d = S_FETCH;
            end
            S_MARK:   if (mem_ready) state_d = S_FETCH;
            S_PERM: begin
                if (chk_done) begin
                    if (!chk_allow)       state_d = S_FINISH;
                    else if (leaf_stale)  state_d = S_UPDATE;
                    else                  state_d = S_FINISH;
                end
            end
            S_UPDATE: if (mem_ready) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            wr_q    <= 1'b0;
            nx_q    <= 1'b0;
            lvl_q   <= '0;
            ent_q   <= '0;
            addr_q  <= '0;
            rw_acc  <= 1'b1;
            us_acc  <= 1'b1;
            nx_acc  <= 1'b0;
            cause_q <= FLT_NONE;
            pa_q    <= '0;
            size_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vpn[VA_BITS-1:PAGE_SHIFT];
                        wr_q    <= req_write;
                        nx_q    <= nx_enable;
                        lvl_q   <= LVL_W'(LEVELS);
                        addr_q  <= next_addr;
                        rw_acc  <= 1'b1;
                        us_acc  <= 1'b1;
                        nx_acc  <= 1'b0;
                        pa_q    <= '0;
                        size_q  <= '0;
                        cause_q <= canonical ? FLT_NONE : FLT_NONCANON;
                    end
                end
                S_FETCH: begin
                    if (mem_ready) ent_q <= mem_rdata;
                end
                S_CHECK: begin
                    if (!e_present) begin
                        cause_q <= FLT_ABSENT;
                    end else if (e_rsvd) begin
                        cause_q <= FLT_RSVD;
                    end else begin
                        rw_acc <= rw_acc & ent_q[B_WRITE];
                        us_acc <= us_acc & ent_q[B_USER];
                        nx_acc <= nx_acc | ent_q[B_NOEXEC];
                        if (e_leaf) begin
                            pa_q   <= leaf_base;
                            size_q <= e_size;
                        end else if (ent_q[B_ACCESSED]) begin
                            addr_q <= next_addr;
                            lvl_q  <= lvl_q - LVL_W'(1);
                        end
                    end
                end
                S_MARK: begin
                    if (mem_ready) begin
                        addr_q <= next_addr;
                        lvl_q  <= lvl_q - LVL_W'(1);
                    end
                end
                S_PERM: begin
                    if (chk_done && !chk_allow) begin
                        cause_q <= FLT_DENY;
                        pa_q    <= '0;
                        size_q  <= '0;
                    end
                end
                S_UPDATE: ;
                S_FINISH: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == S_IDLE);
        mem_valid   = (state_q == S_FETCH) || (state_q == S_MARK) || (state_q == S_UPDATE);
        mem_we      = (state_q == S_MARK) || (state_q == S_UPDATE);
        mem_addr    = addr_q;
        mem_wdata   = ent_q;
        mem_wdata[B_ACCESSED] = 1'b1;
        if (state_q == S_UPDATE && wr_q) mem_wdata[B_DIRTY] = 1'b1;
        chk_req     = (state_q == S_PERM);
        chk_write   = wr_q;
        done        = (state_q == S_FINISH);
        fault       = (cause_q != FLT_NONE);
        fault_cause = cause_q;
        page_pa     = pa_q;
        page_size   = size_q;
        attr_rw     = rw_acc;
        attr_user   = us_acc;
        attr_nx     = nx_acc;
    end

    // R1
    noncanon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !((&req_vpn[63:VA_BITS-1]) || !(|req_vpn[63:VA_BITS-1]))
        |=> done && !mem_valid && fault_cause == 3'd4);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

    // R11
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);

    // R8
    abit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> mem_wdata[B_ACCESSED]);

    // R9
    deny_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req && chk_done && !chk_allow |=> done && !mem_valid && fault_cause == 3'd3);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_valid && !chk_req);

endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:12] req_vpn = '0;
    logic        req_write = 1'b0;
    logic        nx_enable = 1'b0;
    logic [27:0] root_frame = 28'd0;
    logic        mem_valid, mem_we;
    logic        mem_ready = 1'b0;
    logic [39:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;
    logic        chk_req, chk_write;
    logic        deny_q = 1'b0;
    logic        done, fault;
    logic [2:0]  fault_cause;
    logic [39:0] page_pa;
    logic [1:0]  page_size;
    logic        attr_rw, attr_user, attr_nx;

    always #2 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
        .req_write(req_write), .nx_enable(nx_enable), .root_frame(root_frame),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .chk_req(chk_req), .chk_write(chk_write), .chk_done(1'b1), .chk_allow(!deny_q),
        .done(done), .fault(fault), .fault_cause(fault_cause),
        .page_pa(page_pa), .page_size(page_size),
        .attr_rw(attr_rw), .attr_user(attr_user), .attr_nx(attr_nx)
    );

    logic [63:0] mem  [0:4095];
    logic [63:0] smem [0:4095];
    logic [39:0] rd_log [0:7];
    int rd_cnt = 0;
    int wr_cnt = 0;

    assign mem_rdata = mem[mem_addr[14:3]];

    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[14:3]] = mem_wdata;
                wr_cnt = wr_cnt + 1;
            end else begin
                rd_log[rd_cnt[2:0]] = mem_addr;
                rd_cnt = rd_cnt + 1;
            end
        end
    end

    always @(negedge clk) mem_ready <= ($urandom % 3) != 0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model results
    logic [2:0]  m_cause;
    logic [1:0]  m_size;
    logic [39:0] m_pa;
    logic        m_rw, m_us, m_nx;
    int          m_nrd, m_nwr;
    logic [39:0] m_rd [0:3];

    task automatic model(input logic [63:0] va, input logic wr, input logic nxen, input logic deny);
        logic [63:0] e, lowm;
        logic [39:0] a;
        logic [27:0] frame;
        logic leaf, rsv;
        int sh;
        frame = root_frame;
        m_cause = 0; m_size = 0; m_pa = 0; m_rw = 1; m_us = 1; m_nx = 0; m_nrd = 0; m_nwr = 0;
        if (!((&va[63:47]) || !(|va[63:47]))) begin m_cause = 4; return; end
        for (int lvl = 4; lvl >= 1; lvl--) begin
            a = {frame, va[12 + 9*(lvl-1) +: 9], 3'b000};
            m_rd[m_nrd] = a; m_nrd++;
            e = smem[a[14:3]];
            if (!e[0]) begin m_cause = 1; return; end
            leaf = (lvl == 1) || (lvl <= 3 && e[7]);
            rsv = (|e[51:40]) || (!nxen && e[63]) || (lvl == 4 && e[7]);
            sh = 12 + 9*(lvl-1);
            if (leaf && lvl > 1) begin
                lowm = ((64'd1 << sh) - 64'd1) & ~64'h1fff;
                rsv = rsv || (|(e & lowm));
            end
            if (rsv) begin m_cause = 2; return; end
            m_rw = m_rw & e[1]; m_us = m_us & e[2]; m_nx = m_nx | e[63];
            if (leaf) begin
                if (deny) begin m_cause = 3; return; end
                m_size = 2'(lvl - 1);
                m_pa = {e[39:12], 12'b0} & ~40'((64'd1 << sh) - 64'd1);
                if (!e[5] || (wr && !e[6])) begin
                    smem[a[14:3]] = e | 64'h20 | (wr ? 64'h40 : 64'h0);
                    m_nwr++;
                end
                return;
            end
            if (!e[5]) begin smem[a[14:3]] = e | 64'h20; m_nwr++; end
            frame = e[39:12];
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 64'd0;
    endtask

    function automatic logic [8:0] idx_of(input logic [63:0] va, input int lvl);
        return va[12 + 9*(lvl-1) +: 9];
    endfunction

    function automatic logic [63:0] ptr(input int page);
        return (64'(page) << 12) | 64'h1;
    endfunction

    task automatic put(input logic [63:0] va, input int lvl, input logic [63:0] e);
        mem[(4 - lvl)*512 + int'(idx_of(va, lvl))] = e;
    endtask

    task automatic run_case(input logic [63:0] va, input logic wr, input logic nxen, input logic deny);
        int rd0, wr0, cyc, bad;
        string ctag;
        for (int i = 0; i < 4096; i++) smem[i] = mem[i];
        model(va, wr, nxen, deny);
        @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        req_vpn = va[63:12]; req_write = wr; nx_enable = nxen; deny_q = deny;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
        if (!done) begin
            check(1'b0, "R12 walk never completed", 64'(cyc), 64'd0);
            rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
            return;
        end
        case (m_cause)
            3'd0: ctag = "R6 cause";
            3'd1: ctag = "R3 cause";
            3'd2: ctag = "R4 R5 R7 cause";
            3'd3: ctag = "R9 cause";
            default: ctag = "R1 cause";
        endcase
        check(fault_cause == m_cause, ctag, 64'(fault_cause), 64'(m_cause));
        check(fault == (m_cause != 0), "R6 fault flag", 64'(fault), 64'(m_cause != 0));
        if (m_cause == 0) begin
            check(page_pa == m_pa && page_size == m_size, "R6 page",
                  {22'd0, page_size, page_pa}, {22'd0, m_size, m_pa});
            check({attr_nx, attr_user, attr_rw} == {m_nx, m_us, m_rw}, "R10 attributes",
                  64'({attr_nx, attr_user, attr_rw}), 64'({m_nx, m_us, m_rw}));
        end
        bad = 0;
        for (int k = 0; k < m_nrd && k < 4; k++) if (rd_log[(rd0 + k) % 8] != m_rd[k]) bad++;
        check(rd_cnt - rd0 == m_nrd && bad == 0, "R2 read sequence",
              64'(rd_cnt - rd0), 64'(m_nrd));
        check(wr_cnt - wr0 == m_nwr, "R8 write-back count", 64'(wr_cnt - wr0), 64'(m_nwr));
        bad = 0;
        for (int i = 0; i < 4096; i++) if (mem[i] !== smem[i]) bad++;
        check(bad == 0, "R9 table image after walk", 64'(bad), 64'd0);
        @(negedge clk);
        check(!done && req_ready, "R12 done single cycle, R11 ready after",
              64'({done, req_ready}), 64'b01);
    endtask

    task automatic rand_case();
        logic [63:0] va, e;
        logic wr, nxen, deny, ps, leaf;
        int sh;
        clear_mem();
        nxen = ($urandom % 10) < 7;
        wr   = $urandom % 2;
        deny = ($urandom % 100) < 15;
        va = {$urandom, $urandom};
        va[63:48] = {16{va[47]}};
        if ($urandom % 20 == 0) va[55] = ~va[55];
        for (int lvl = 4; lvl >= 1; lvl--) begin
            e = 64'd0;
            e[0] = ($urandom % 12) != 0;
            e[1] = $urandom % 2; e[2] = $urandom % 2;
            e[4:3] = 2'($urandom); e[11:8] = 4'($urandom);
            e[5] = $urandom % 2; e[6] = $urandom % 2;
            e[63] = nxen ? 1'($urandom % 2) : (($urandom % 20) == 0);
            case (lvl)
                4: ps = ($urandom % 25) == 0;
                3: ps = ($urandom % 4) == 0;
                2: ps = ($urandom % 3) == 0;
                default: ps = $urandom % 2;
            endcase
            e[7] = ps;
            leaf = (lvl == 1) || (ps && lvl < 4);
            if (!leaf) begin
                e[39:12] = 28'(5 - lvl);
            end else begin
                e[39:12] = 28'($urandom);
                if (lvl > 1) begin
                    sh = 12 + 9*(lvl-1);
                    if ($urandom % 5 != 0)
                        e = e & ~(((64'd1 << sh) - 64'd1) & ~64'h1fff);
                end
            end
            if ($urandom % 25 == 0) e[40 + ($urandom % 12)] = 1'b1;
            put(va, lvl, e);
            if (leaf) break;
        end
        run_case(va, wr, nxen, deny);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] va;
        void'($urandom(32'd4242));
        clear_mem();
        repeat (3) @(negedge clk);
        check(req_ready && !done && !mem_valid && !chk_req, "R11 reset state",
              64'({req_ready, done, mem_valid, chk_req}), 64'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !mem_valid, "R11 idle after reset", 64'({req_ready, mem_valid}), 64'b10);

        // R1: upper bits break sign extension
        clear_mem();
        run_case(64'h0000_8000_1234_5000, 1'b0, 1'b1, 1'b0);

        va = 64'h0000_1234_5678_9000;
        // R8: all flags already set, 4 KB read, no writes at all
        clear_mem();
        put(va, 4, ptr(1) | 64'h26); put(va, 3, ptr(2) | 64'h26); put(va, 2, ptr(3) | 64'h26);
        put(va, 1, (64'h0ab_cdef1 << 12) | 64'h67);
        run_case(va, 1'b1, 1'b1, 1'b0);

        // R7: 1 GB leaf with bit 12 set is legal
        clear_mem();
        put(va, 4, ptr(1)); put(va, 3, (64'h5 << 30) | 64'h1087);
        run_case(va, 1'b0, 1'b1, 1'b0);

        // R7: 2 MB leaf with bit 13 set is reserved
        clear_mem();
        put(va, 4, ptr(1)); put(va, 3, ptr(2)); put(va, 2, (64'h7 << 21) | 64'h2081);
        run_case(va, 1'b0, 1'b1, 1'b0);

        // R5: large flag on the top entry
        clear_mem();
        put(va, 4, ptr(1) | 64'h80);
        run_case(va, 1'b0, 1'b1, 1'b0);

        // R4: bit 63 with no-execute disabled
        clear_mem();
        put(va, 4, ptr(1)); put(va, 3, ptr(2)); put(va, 2, ptr(3) | 64'h8000_0000_0000_0000);
        run_case(va, 1'b0, 1'b0, 1'b0);

        // R4: physical bit above the supported width
        clear_mem();
        put(va, 4, ptr(1) | (64'd1 << 45));
        run_case(va, 1'b0, 1'b1, 1'b0);

        // R3: absent at level 1 after three reads
        clear_mem();
        put(va, 4, ptr(1)); put(va, 3, ptr(2)); put(va, 2, ptr(3)); put(va, 1, 64'h0000_0123_4000);
        run_case(va, 1'b1, 1'b1, 1'b0);

        // R9: denied leaf with clear flags, only non-leaf marks written
        clear_mem();
        put(va, 4, ptr(1)); put(va, 3, ptr(2)); put(va, 2, ptr(3)); put(va, 1, (64'h42 << 12) | 64'h7);
        run_case(va, 1'b1, 1'b1, 1'b1);

        // R9: accessed but clean leaf on a write gets dirty
        clear_mem();
        put(va, 4, ptr(1) | 64'h20); put(va, 3, ptr(2) | 64'h20); put(va, 2, (64'h9 << 21) | 64'hA3);
        run_case(va, 1'b1, 1'b1, 1'b0);

        for (int t = 0; t < 400; t++) rand_case();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule